// File: doc/BRIEF.md
# Multi-CPU Banked Interrupt Aggregator

The block collects `NWORDS*32` level-sensitive interrupt source lines and presents them to `NCPUS` processors. Each processor owns a private register bank holding one enable word and one status word per group of 32 sources. A processor's interrupt output is raised whenever a source that is pending is also enabled in that processor's bank. Software routes a source to one CPU, several CPUs or none, using only the enable bits in each bank.

Sources pass through a small synchronizer, and the synchronized level is what the status words show. Masking is a read-modify-write of one enable word, because a write replaces the whole word. Banks sit back to back in the address space. Inside a bank the enable words come first and the status words follow. Word order is reversed, so the lowest word address covers the highest-numbered sources.

The bus is a single-cycle request (`bus_req`, `bus_we`, byte address, write data). Read data is registered and appears on `bus_rdata` one clock after the read request.

Top module: `irqagg_top`

## Requirements
- R1: After reset every enable word reads as zero, every `irq_o` bit is 0 and `bus_rdata` is 0.
- R2: CPU c's bank starts at byte address c*8*NWORDS. Within it, enable word k sits at offset 4*k and status word k at offset 4*NWORDS+4*k, for k in 0..NWORDS-1.
- R3: Register word k (enable or status) covers source group NWORDS-1-k: bit b of word k corresponds to source line (NWORDS-1-k)*32+b.
- R4: A write to an enable word replaces the whole word with `bus_wdata`, and a later read returns exactly that value.
- R5: A status word shows the level of its source lines as sampled by SYNC_STAGES registers, so a source change is visible SYNC_STAGES clocks later. Writes to status addresses change nothing, neither the status nor any enable word nor any output.
- R6: `irq_o[c]` is a register that takes the OR over all groups of (status AND CPU c's enable). It changes one clock after the enable word or the status changes.
- R7: Banks are independent. A write to one CPU's enable word leaves all other banks unchanged, and a source enabled in several banks raises every one of those CPUs' outputs.
- R8: An address at or above NCPUS*8*NWORDS, or one with a nonzero value in its two low bits, is unmapped. A read of it returns 0 and a write to it has no effect.
- R9: `bus_rdata` is loaded only on a read request, one clock after the request. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NWORDS*32 | Level-sensitive interrupt source lines |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NCPUS | Per-CPU interrupt outputs |

## Verification
The bench builds the block with NWORDS=3 and NCPUS=3, for a map of 72 bytes. A bank size that is not a power of two exercises the division in the address decode. A middle word exercises the group reversal away from both ends. The unmapped range above the last bank is also reachable within an 8-bit address. Three CPUs let a single write be checked for leaving two other banks untouched, and let one source be enabled on a subset of the CPUs.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned GROUP_BITS = 32;
    localparam int unsigned WORD_BYTES = 4;

    typedef logic [GROUP_BITS-1:0] grp_word_t;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_STATUS = 2'd2
    } reg_kind_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned WIDTH  = 64,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            pipe_q[0] <= src_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign level_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int unsigned NWORDS = 2,
    parameter int unsigned NCPUS  = 2,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned CPU_W = (NCPUS > 1) ? $clog2(NCPUS) : 1,
    localparam int unsigned GRP_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [CPU_W-1:0]  cpu_o,
    output logic [GRP_W-1:0]  grp_o
);
    localparam int unsigned BANK_BYTES  = 2 * WORD_BYTES * NWORDS;
    localparam int unsigned TOTAL_BYTES = BANK_BYTES * NCPUS;

    int unsigned a;
    int unsigned cpu_n;
    int unsigned slot;

    always_comb begin
        a      = 32'(addr_i);
        cpu_n  = a / BANK_BYTES;
        slot   = (a % BANK_BYTES) / WORD_BYTES;
        kind_o = REG_NONE;
        cpu_o  = '0;
        grp_o  = '0;
        if (a[1:0] == 2'b00 && a < TOTAL_BYTES) begin
            cpu_o = CPU_W'(cpu_n);
            if (slot < NWORDS) begin
                kind_o = REG_ENABLE;
                grp_o  = GRP_W'(NWORDS - 1 - slot);
            end else begin
                kind_o = REG_STATUS;
                grp_o  = GRP_W'(2 * NWORDS - 1 - slot);
            end
        end
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int unsigned NWORDS = 2,
    localparam int unsigned GRP_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int unsigned SRC_W = NWORDS * GROUP_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [GRP_W-1:0] grp_i,
    input  grp_word_t        wdata_i,
    input  logic [SRC_W-1:0] status_i,
    output logic [SRC_W-1:0] enable_o,
    output logic             irq_o
);
    grp_word_t en_q [NWORDS];
    logic      any_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < int'(NWORDS); g++) begin
                en_q[g] <= '0;
            end
        end else begin
            for (int g = 0; g < int'(NWORDS); g++) begin
                if (wr_en_i && grp_i == GRP_W'(g)) begin
                    en_q[g] <= wdata_i;
                end
            end
        end
    end

    for (genvar g = 0; g < int'(NWORDS); g++) begin : g_flat
        assign enable_o[g*GROUP_BITS +: GROUP_BITS] = en_q[g];
    end

    always_comb begin
        any_hit = |(status_i & enable_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= any_hit;
        end
    end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned NWORDS      = 2,
    parameter int unsigned NCPUS       = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWORDS*32-1:0]     src_i,
    input  logic                     bus_req,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [NCPUS-1:0]         irq_o
);
    localparam int unsigned CPU_W = (NCPUS > 1) ? $clog2(NCPUS) : 1;
    localparam int unsigned GRP_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int unsigned SRC_W = NWORDS * GROUP_BITS;

    logic [SRC_W-1:0] status_q;
    logic [SRC_W-1:0] en_all [NCPUS];
    reg_kind_e        kind;
    logic [CPU_W-1:0] cpu_sel;
    logic [GRP_W-1:0] grp_sel;
    grp_word_t        rd_val;
    grp_word_t        rdata_q;

    irqagg_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .level_o (status_q)
    );

    irqagg_decode #(.NWORDS(NWORDS), .NCPUS(NCPUS), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .kind_o (kind),
        .cpu_o  (cpu_sel),
        .grp_o  (grp_sel)
    );

    for (genvar c = 0; c < int'(NCPUS); c++) begin : g_bank
        logic wr_here;
        assign wr_here = bus_req && bus_we && (kind == REG_ENABLE)
                         && (cpu_sel == CPU_W'(c));
        irqagg_bank #(.NWORDS(NWORDS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_here),
            .grp_i    (grp_sel),
            .wdata_i  (bus_wdata),
            .status_i (status_q),
            .enable_o (en_all[c]),
            .irq_o    (irq_o[c])
        );
    end

    always_comb begin
        rd_val = '0;
        unique case (kind)
            REG_ENABLE: begin
                for (int c = 0; c < int'(NCPUS); c++) begin
                    for (int g = 0; g < int'(NWORDS); g++) begin
                        if (cpu_sel == CPU_W'(c) && grp_sel == GRP_W'(g)) begin
                            rd_val = en_all[c][g*GROUP_BITS +: GROUP_BITS];
                        end
                    end
                end
            end
            REG_STATUS: begin
                for (int g = 0; g < int'(NWORDS); g++) begin
                    if (grp_sel == GRP_W'(g)) begin
                        rd_val = status_q[g*GROUP_BITS +: GROUP_BITS];
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_req && !bus_we) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int unsigned NWORDS = 2,
    parameter int unsigned NCPUS  = 2,
    parameter int unsigned ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_rdata,
    input logic [NCPUS-1:0]     irq_o,
    input logic [NWORDS*32-1:0] status
);
    localparam int unsigned MAP_BYTES = NCPUS * 8 * NWORDS;

    logic unmapped;
    assign unmapped = (bus_addr[1:0] != 2'b00) || (32'(bus_addr) >= MAP_BYTES);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

    p_irq_from_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> $past(|status));

    p_no_status_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> (irq_o == '0));

    p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && unmapped) |=> (bus_rdata == 32'd0));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

bind irqagg_top irqagg_chk #(.NWORDS(NWORDS), .NCPUS(NCPUS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .status    (status_q)
);

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;
    localparam int NW = 3;
    localparam int NC = 3;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NW*32-1:0] src = '0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   irq_o;

    logic [31:0] en_m [NC][NW];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqagg_top #(.NWORDS(NW), .NCPUS(NC), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic int en_addr(int c, int g);
        return c*8*NW + 4*(NW-1-g);
    endfunction

    function automatic int st_addr(int c, int g);
        return c*8*NW + 4*NW + 4*(NW-1-g);
    endfunction

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++)
                if ((src[g*32 +: 32] & en_m[c][g]) != 0) r[c] = 1'b1;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(int addr, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(int addr, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_en(int c, int g, logic [31:0] v);
        bus_write(en_addr(c, g), v);
        en_m[c][g] = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++) en_m[c][g] = '0;

        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq_o), 32'd0);
        check("R1 rdata in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++) begin
                bus_read(en_addr(c, g), d);
                check("R1 enable reset value", d, 32'd0);
            end

        // R2/R4: distinct values per register, read back through the map
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++) set_en(c, g, 32'hA000_0000 | 32'(c*16 + g));
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++) begin
                bus_read(en_addr(c, g), d);
                check("R2 R4 enable readback", d, en_m[c][g]);
            end
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < NW; g++) set_en(c, g, 32'd0);

        // R3: single source lines land in reversed word order
        src = '0; src[0] = 1'b1; settle();
        bus_read(st_addr(0, 0), d); check("R3 source 0 in last status word", d, 32'd1);
        bus_read(4*NW, d); check("R3 first status word empty", d, 32'd0);
        src = '0; src[NW*32-1] = 1'b1; settle();
        bus_read(4*NW, d); check("R3 top source in first status word", d, 32'h8000_0000);
        src = '0; src[37] = 1'b1; settle();
        bus_read(4*NW + 4, d); check("R3 middle word bit5", d, 32'h0000_0020);

        // R5: status latency and read-only behaviour
        src = '0; settle();
        set_en(1, 2, 32'h0000_0100);
        @(negedge clk);
        src[2*32 + 8] = 1'b1;
        @(negedge clk);
        check("R5 status not yet after one clock", 32'(irq_o), 32'd0);
        @(negedge clk);
        check("R6 irq one clock after status", 32'(irq_o), 32'd0);
        @(negedge clk);
        check("R5 R6 irq after sync plus one", 32'(irq_o), 32'b010);
        bus_write(st_addr(1, 2), 32'h0);
        bus_write(st_addr(0, 1), 32'hFFFF_FFFF);
        bus_read(st_addr(2, 2), d); check("R5 status write ignored", d, 32'h0000_0100);
        bus_read(st_addr(0, 1), d); check("R5 status write ignored other word", d, 32'd0);
        bus_read(en_addr(1, 2), d); check("R5 enable untouched by status write", d, 32'h0000_0100);
        check("R5 irq untouched by status write", 32'(irq_o), 32'b010);

        // R6: enable-driven latency
        set_en(1, 2, 32'd0); settle();
        check("R6 masked irq low", 32'(irq_o), 32'd0);
        bus_write(en_addr(2, 2), 32'h0000_0100);
        en_m[2][2] = 32'h0000_0100;
        check("R6 irq not before next clock", 32'(irq_o), 32'd0);
        @(negedge clk);
        check("R6 irq one clock after enable write", 32'(irq_o), 32'b100);

        // R7: banks independent, multi-CPU enable
        set_en(0, 2, 32'h0000_0100); settle();
        check("R7 source on two CPUs", 32'(irq_o), 32'b101);
        set_en(1, 0, 32'h1234_5678);
        bus_read(en_addr(0, 0), d); check("R7 cpu0 bank untouched", d, 32'd0);
        bus_read(en_addr(2, 0), d); check("R7 cpu2 bank untouched", d, 32'd0);
        bus_read(en_addr(0, 2), d); check("R7 cpu0 other word kept", d, 32'h0000_0100);

        // R8: unmapped accesses
        bus_write(NC*8*NW, 32'hFFFF_FFFF);
        bus_write(1, 32'hFFFF_FFFF);
        bus_write(en_addr(2, 0) + 2, 32'hFFFF_FFFF);
        bus_write(255, 32'hFFFF_FFFF);
        bus_read(en_addr(0, 2), d); check("R8 misaligned write ignored", d, 32'h0000_0100);
        bus_read(en_addr(2, 0), d); check("R8 misaligned write ignored cpu2", d, 32'd0);
        bus_read(en_addr(1, 0), d); check("R9 prime nonzero rdata", d, 32'h1234_5678);
        bus_read(NC*8*NW, d); check("R8 read past map is zero", d, 32'd0);
        bus_read(en_addr(1, 0), d);
        bus_read(en_addr(1, 0) + 1, d); check("R8 misaligned read is zero", d, 32'd0);
        bus_read(200, d); check("R8 far read is zero", d, 32'd0);
        settle();
        check("R8 irq unchanged", 32'(irq_o), 32'(exp_irq()));

        // R9: rdata holds through idle and writes
        bus_read(en_addr(1, 0), d);
        repeat (3) @(negedge clk);
        check("R9 rdata holds idle", bus_rdata, 32'h1234_5678);
        set_en(0, 0, 32'hDEAD_BEEF);
        check("R9 rdata holds over write", bus_rdata, 32'h1234_5678);

        // R6/R4 random mix
        for (int it = 0; it < 200; it++) begin
            int c = int'($urandom % NC);
            int g = int'($urandom % NW);
            if ($urandom % 2 == 0) begin
                for (int w = 0; w < NW; w++)
                    src[w*32 +: 32] = $urandom & $urandom & $urandom;
            end else begin
                v = $urandom & $urandom;
                set_en(c, g, v);
            end
            settle();
            check("R6 random irq", 32'(irq_o), 32'(exp_irq()));
            if (it % 8 == 0) begin
                bus_read(st_addr(c, g), d);
                check("R3 random status word", d, src[g*32 +: 32]);
                bus_read(en_addr(c, g), d);
                check("R4 random enable word", d, en_m[c][g]);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule